// File: doc/BRIEF.md
# Lane Deskew Calibration Sequencer

This block sequences deskew calibration for the receive side of a multi-lane serial link. Once the link clock has locked, it opens a calibration window of a fixed length. For the whole window it enables the external strobe-adjust logic and keeps the parallel data output at zero. When the window closes, it passes received words through a single output register.

A deskew control input, high in normal use, lets the system ask for a new calibration. A low level lasting more than four clocks stops normal traffic and puts the block into a hold state. In that state the strobes keep recalibrating for as long as the level stays low. When the input returns high, a complete new window runs. Loss of lock stops traffic and waits for lock again. The power-enable input clears the outputs while it is low. A sticky flag reports any calibration window in which a cycle saw no change on the incoming word, because the strobe search needs at least one transition per clock.

The output is a stream with a valid strobe and no ready. The sink must accept a beat on every cycle that valid is high, and it cannot apply back-pressure. Valid is high only in normal operation.

Top module: `lane_deskew_seq`

## Requirements
- R1: While reset is asserted and after its release, out_valid_o, out_data_o, cal_en_o and no_activity_o are all zero.
- R2: If pwr_en_i is sampled low at a clock edge, out_valid_o, out_data_o and cal_en_o are all zero after that edge.
- R3: With pwr_en_i high and pll_lock_i low, cal_en_o and out_valid_o stay zero, and no calibration starts.
- R4: The first edge that samples lock high, with the block waiting for lock, starts a window. cal_en_o is high for exactly CAL_CYCLES (default 4096) cycles and out_valid_o is low throughout. On the next edge cal_en_o falls and out_valid_o rises.
- R5: In normal operation every edge loads out_data_o with the rx_data_i value sampled at that edge and holds out_valid_o at 1. Whenever out_valid_o is 0, out_data_o is 0.
- R6: A low pulse on dsk_ctl_i lasting MIN_LOW (default 4) clocks or fewer is ignored, and out_valid_o stays high.
- R7: A dsk_ctl_i low level sampled on MIN_LOW+1 consecutive edges clears out_valid_o on the following edge and raises cal_en_o. Both stay that way while the level is held low. The edge that samples the input high again starts a full R4 window.
- R8: If pll_lock_i is sampled low in any state, out_valid_o and cal_en_o are zero after that edge. When lock returns, a full R4 window runs.
- R9: no_activity_o is set when, during a calibration window, an edge samples rx_data_i equal to its value at the previous edge. It then holds through normal operation and clears on the edge that starts the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered parallel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_en_i | input | 1 | High to operate, low forces outputs to zero |
| pll_lock_i | input | 1 | Clock lock indication |
| dsk_ctl_i | input | 1 | Deskew control, high in normal use, long low requests calibration |
| rx_data_i | input | DW | Parallel word from the lane samplers |
| out_data_o | output | DW | Registered output word |
| out_valid_o | output | 1 | Output beat valid, with no ready |
| cal_en_o | output | 1 | Enables the strobe-adjust logic |
| no_activity_o | output | 1 | Sticky flag: a calibration cycle saw no input transition |

## Verification
A sequencer stuck in the wrong state shows at once on out_valid_o and cal_en_o. Either both are high, or valid stays low after a window, or valid stays high one edge after power or lock is removed. A window counter that is off by one moves the valid rise by one edge, and a check sampled one cycle before and one cycle after that edge catches it. A pulse filter with the wrong threshold either drops valid during a four-clock pulse or keeps it high after a five-clock pulse, one edge after the pulse ends.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
  typedef enum logic [2:0] {
    ST_OFF        = 3'd0,
    ST_WAIT_LOCK  = 3'd1,
    ST_CAL        = 3'd2,
    ST_RUN        = 3'd3,
    ST_RECAL_HOLD = 3'd4
  } seq_state_e;
endpackage

// File: rtl/lds_low_filter.sv
// Measures how long the control input has been low; saturates one above the ignore limit.
module lds_low_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_i,
  output logic long_low_o
);
  localparam int SAT = MIN_LOW + 1;
  localparam int LW  = $clog2(SAT + 1);
  localparam logic [LW-1:0] SAT_V = LW'(SAT);

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_cnt_q <= '0;
    else if (ctl_i)           low_cnt_q <= '0;
    else if (low_cnt_q != SAT_V) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign long_low_o = (low_cnt_q == SAT_V);
endmodule

// File: rtl/lds_cal_timer.sv
// Counts cycles spent in the calibration window.
module lds_cal_timer #(
  parameter int CAL_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/lds_activity_mon.sv
// Flags a calibration cycle in which no input bit changed.
module lds_activity_mon #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          watch_i,
  input  logic          clear_i,
  output logic          flag_o
);
  logic [DW-1:0] prev_q;
  logic [DW-1:0] same;
  logic          flag_q;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign same[b] = (data_i[b] == prev_q[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= data_i;
      if (clear_i)               flag_q <= 1'b0;
      else if (watch_i && &same) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/lds_out_stage.sv
// Output register: passes the word only when loading, zero otherwise.
module lds_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      data_o  <= data_i;
      valid_o <= 1'b1;
    end else begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_deskew_seq.sv
module lane_deskew_seq
  import lane_deskew_pkg::*;
#(
  parameter int DW         = 16,
  parameter int CAL_CYCLES = 4096,
  parameter int MIN_LOW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_en_i,
  input  logic          pll_lock_i,
  input  logic          dsk_ctl_i,
  input  logic [DW-1:0] rx_data_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o,
  output logic          cal_en_o,
  output logic          no_activity_o
);
  seq_state_e state_q, state_d;
  logic long_low, win_done, win_start;

  lds_low_filter #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(dsk_ctl_i), .long_low_o(long_low)
  );

  lds_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_CAL), .done_o(win_done)
  );

  // Next state: power first, then lock, then the per-state rules.
  always_comb begin
    state_d = state_q;
    if (!pwr_en_i) begin
      state_d = ST_OFF;
    end else if (!pll_lock_i) begin
      state_d = ST_WAIT_LOCK;
    end else begin
      unique case (state_q)
        ST_OFF:        state_d = ST_WAIT_LOCK;
        ST_WAIT_LOCK:  state_d = ST_CAL;
        ST_CAL:        state_d = long_low ? ST_RECAL_HOLD : (win_done ? ST_RUN : ST_CAL);
        ST_RUN:        state_d = long_low ? ST_RECAL_HOLD : ST_RUN;
        ST_RECAL_HOLD: state_d = dsk_ctl_i ? ST_CAL : ST_RECAL_HOLD;
        default:       state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign win_start = (state_d == ST_CAL) && (state_q != ST_CAL);
  assign cal_en_o  = (state_q == ST_CAL) || (state_q == ST_RECAL_HOLD);

  lds_activity_mon #(.DW(DW)) u_act (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(rx_data_i),
    .watch_i(state_q == ST_CAL), .clear_i(win_start), .flag_o(no_activity_o)
  );

  lds_out_stage #(.DW(DW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(state_d == ST_RUN),
    .data_i(rx_data_i), .data_o(out_data_o), .valid_o(out_valid_o)
  );
endmodule

// File: rtl/lane_deskew_seq_chk.sv
module lane_deskew_seq_chk #(
  parameter int DW         = 16,
  parameter int CAL_CYCLES = 4096
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_en_i,
  input logic          pll_lock_i,
  input logic [DW-1:0] out_data_o,
  input logic          out_valid_o,
  input logic          cal_en_o,
  input logic          no_activity_o
);
  localparam int RW = $clog2(CAL_CYCLES + 1);
  localparam logic [RW-1:0] FULL = RW'(CAL_CYCLES);

  // Consecutive cycles with cal_en_o high, saturating at one full window.
  logic [RW-1:0] cal_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cal_run_q <= '0;
    else if (!cal_en_o)     cal_run_q <= '0;
    else if (cal_run_q != FULL) cal_run_q <= cal_run_q + 1'b1;
  end

  p_pd_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> (!out_valid_o && out_data_o == '0 && !cal_en_o));

  p_lock_loss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |=> (!out_valid_o && !cal_en_o));

  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> out_data_o == '0);

  p_cal_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_en_o |-> !out_valid_o);

  p_full_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> cal_run_q == FULL);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_activity_o && out_valid_o) |=> no_activity_o);
endmodule

bind lane_deskew_seq lane_deskew_seq_chk #(.DW(DW), .CAL_CYCLES(CAL_CYCLES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_en_i(pwr_en_i), .pll_lock_i(pll_lock_i),
  .out_data_o(out_data_o), .out_valid_o(out_valid_o), .cal_en_o(cal_en_o),
  .no_activity_o(no_activity_o)
);

// File: tb/lane_deskew_seq_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_seq_tb_top;
  localparam int DW   = 16;
  localparam int CALN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0;
  logic lock = 1'b0;
  logic dsk = 1'b1;
  logic auto_tog = 1'b1;
  logic [DW-1:0] man_data = '0;
  logic [DW-1:0] tog_cnt = '0;
  logic [DW-1:0] rx_data;
  logic [DW-1:0] out_data;
  logic out_valid, cal_en, no_act;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) tog_cnt <= tog_cnt + 16'd1;
  assign rx_data = auto_tog ? tog_cnt : man_data;

  lane_deskew_seq #(.DW(DW), .CAL_CYCLES(CALN), .MIN_LOW(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr_en), .pll_lock_i(lock),
    .dsk_ctl_i(dsk), .rx_data_i(rx_data), .out_data_o(out_data),
    .out_valid_o(out_valid), .cal_en_o(cal_en), .no_activity_o(no_act)
  );

  // Fields: {pwr_en, dsk, expected valid, spare, data}
  localparam int NV = 12;
  localparam logic [19:0] TV [NV] = '{
    {4'b1110, 16'hA5A5}, {4'b1110, 16'h5A5A}, {4'b1010, 16'hFFFF},
    {4'b1010, 16'h0000}, {4'b1010, 16'h1234}, {4'b1010, 16'h8001},
    {4'b1110, 16'hFEDC}, {4'b1110, 16'h0F0F}, {4'b1010, 16'h7777},
    {4'b1110, 16'h3C3C}, {4'b1110, 16'hC3C3}, {4'b0100, 16'hBEEF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Call at a negedge; the next posedge must be the one that starts the window.
  task automatic cal_window(input string req);
    @(posedge clk); @(negedge clk);
    chk(cal_en && !out_valid, req, {cal_en, out_valid}, 2'b10);
    repeat (CALN - 1) @(posedge clk);
    @(negedge clk);
    chk(cal_en && !out_valid, req, {cal_en, out_valid}, 2'b10);
    @(posedge clk); @(negedge clk);
    chk(!cal_en && out_valid, req, {cal_en, out_valid}, 2'b01);
  endtask

  task automatic long_pulse();
    @(negedge clk) dsk = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(out_valid, "R6 last edge before threshold", out_valid, 1);
    dsk = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!out_valid && cal_en, "R7 restart after five lows", {cal_en, out_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({out_valid, out_data, cal_en, no_act} == '0, "R1 in reset",
        {out_valid, cal_en, no_act}, 0);
    rst_n = 1'b1;
    lock  = 1'b1;
    repeat (4) @(negedge clk);
    chk({out_valid, out_data, cal_en, no_act} == '0, "R1 after reset",
        {out_valid, cal_en, no_act}, 0);
    chk(!cal_en && !out_valid, "R2 power off with lock high", {cal_en, out_valid}, 0);

    pwr_en = 1'b1; lock = 1'b0;
    repeat (10) @(negedge clk);
    chk(!cal_en && !out_valid, "R3 no lock", {cal_en, out_valid}, 0);

    lock = 1'b1;
    cal_window("R4 first window");
    chk(!no_act, "R9 toggling data", no_act, 0);

    // Vector walk in normal operation.
    auto_tog = 1'b0;
    for (int i = 0; i < NV; i++) begin
      pwr_en   = TV[i][19];
      dsk      = TV[i][18];
      man_data = TV[i][15:0];
      @(posedge clk); @(negedge clk);
      chk(out_valid == TV[i][17], "R5/R6 valid", out_valid, TV[i][17]);
      chk(out_data == (TV[i][17] ? TV[i][15:0] : 16'h0), "R5/R2 data", out_data,
          TV[i][17] ? TV[i][15:0] : 16'h0);
    end
    chk(!cal_en, "R2 off after vector walk", cal_en, 0);
    auto_tog = 1'b1; dsk = 1'b1; pwr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    cal_window("R4 after power");

    long_pulse();
    cal_window("R7 window after pulse");

    // Held low: continuous recalibration.
    dsk = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(cal_en && !out_valid, "R7 held low start", {cal_en, out_valid}, 2'b10);
    repeat (25) @(posedge clk);
    @(negedge clk);
    chk(cal_en && !out_valid && out_data == 0, "R7 held low", {cal_en, out_valid}, 2'b10);
    dsk = 1'b1;
    cal_window("R7 window after release");

    // Lock loss.
    lock = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!cal_en && !out_valid, "R8 lock lost", {cal_en, out_valid}, 0);
    repeat (5) @(negedge clk);
    chk(!cal_en && !out_valid, "R8 waiting", {cal_en, out_valid}, 0);
    lock = 1'b1;
    cal_window("R8 window after relock");

    // Window with a frozen input word.
    auto_tog = 1'b0; man_data = 16'h0042;
    long_pulse();
    cal_window("R4 frozen window");
    chk(no_act, "R9 set by frozen data", no_act, 1);
    repeat (20) @(negedge clk);
    chk(no_act, "R9 sticky in run", no_act, 1);
    auto_tog = 1'b1;
    long_pulse();
    chk(no_act, "R9 holds during hold state", no_act, 1);
    @(posedge clk); @(negedge clk);
    chk(!no_act, "R9 cleared at window start", no_act, 0);
    repeat (CALN + 2) @(negedge clk);
    chk(!no_act && out_valid, "R9 stays clear", {no_act, out_valid}, 2'b01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule